// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Sequencer

This block runs one complete transaction on a three-wire serial EEPROM. Its pins are an active-high chip select, a serial clock, a data line to the memory and a data line from the memory. A host pulses a start strobe with an operation code, a 7-bit address, optional write data and the lengths of the data and read fields. The sequencer then builds the command frame and shifts it out MSB first. The clock high time, clock low time, data setup time, chip-select setup time and chip-select low time are each set by a parameter counted in system-clock cycles.

What happens after the frame depends on the operation. A read issues one throw-away clock pulse, because the memory sends a leading zero, and then clocks in the requested number of bits. Programming operations (write, erase, write-all, erase-all) drop chip select briefly, raise it again, and then sample the memory's data line in a bounded number of poll windows until the memory reports that it is ready. Enable and disable operations simply end. A one-cycle completion pulse follows. The read data and a timeout flag are held until the next accepted start.

Top module: `mw_seq`

## Requirements
- R1: After synchronous reset, and whenever no transaction is running, chip select, serial clock and data-in are low and busy and done are low.
- R2: The 10-bit command header is sent first, MSB first. Bit 9 is a 1. Bits 8:7 carry the opcode: read 10, write 01, erase 11, special 00. Bits 6:0 carry the address. For special commands, bits 6:5 carry a subcode (disable 00, write-all 01, erase-all 10, enable 11) and bits 4:0 carry address bits 4:0. The op_i codes are: 0 read, 1 write, 2 erase, 3 enable, 4 disable, 5 write-all, 6 erase-all, 7 treated as disable.
- R3: Chip select rises in the cycle after an accepted start and stays high for T_CSS cycles before the first bit phase. At the end of a transaction it is low for T_CS cycles before done.
- R4: Each transmitted bit occupies T_DIS setup cycles, then T_SKH cycles with the clock high, then T_SKL cycles with the clock low, and data-in holds the bit through all three. Write and write-all append data_bits_m1_i+1 bits of wdata_i (LSB-aligned) after the header, MSB first. Data-in is low outside transmit bit phases.
- R5: On a read, the last header bit is followed at once by one dummy pulse (T_SKH high, T_SKL low), whose value is discarded. Then read_bits_m1_i+1 pulses follow, with the data-out line sampled in the last cycle of each low phase. The result is shifted in MSB first and right-aligned in rdata_o.
- R6: Write, erase, write-all and erase-all then drive chip select low for T_CS cycles and high for T_CSS cycles. Up to POLL_MAX windows of T_POLL cycles follow, with the data-out line sampled in the last cycle of each window. A high sample ends the transaction with no timeout.
- R7: If none of the POLL_MAX samples is high, timeout_o is set.
- R8: Enable and disable send only the header and then end, with no data, no polling and no clock pulses beyond the header.
- R9: done_o pulses for one cycle in the first idle cycle. rdata_o (zero for non-read operations) and timeout_o are cleared by an accepted start and hold their values while idle.
- R10: A start strobe while busy is ignored, and the running transaction continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| op_i | input | 3 | Operation code (see R2) |
| addr_i | input | 7 | Memory address |
| wdata_i | input | 16 | Write data, LSB-aligned |
| data_bits_m1_i | input | 4 | Write data length minus one |
| read_bits_m1_i | input | 4 | Read length minus one |
| eep_do_i | input | 1 | Data line from the memory |
| eep_cs_o | output | 1 | Chip select, active high |
| eep_sclk_o | output | 1 | Serial clock |
| eep_di_o | output | 1 | Data line to the memory |
| busy_o | output | 1 | Transaction running |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read result, right-aligned |
| timeout_o | output | 1 | Polling expired without ready |

## Verification
Every internal fault shows up on the four memory pins. A phase counter that is off by one shifts every later edge of chip select or of the clock, and the per-cycle comparison catches this in the same cycle. A wrong bit count or stage shows up as a missing or extra clock pulse within one bit period. A wrong sample point or shift direction corrupts rdata_o, and a wrong poll count or timeout decision changes the length of the polling phase and the flag. Both of these are seen no later than the done pulse.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int HDR_BITS  = 10;
    localparam int DATA_MAX  = 16;
    localparam int FRAME_MAX = HDR_BITS + DATA_MAX;
    localparam int ADDR_W    = 7;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_ERASE = 3'd2,
        OP_WREN  = 3'd3,
        OP_WRDIS = 3'd4,
        OP_WRALL = 3'd5,
        OP_ERALL = 3'd6,
        OP_RSVD  = 3'd7
    } mw_op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CSS, ST_SETUP, ST_HIGH, ST_LOW, ST_CSLO, ST_POLL, ST_END
    } mw_state_e;

    typedef enum logic [1:0] {
        SG_TX, SG_DUMMY, SG_RX, SG_POLL
    } mw_stage_e;

    typedef struct packed {
        logic is_read;
        logic has_data;
        logic polls;
    } mw_class_t;

    function automatic logic [HDR_BITS-1:0] mw_header(mw_op_e op, logic [ADDR_W-1:0] a);
        case (op)
            OP_READ:  return {1'b1, 2'b10, a};
            OP_WRITE: return {1'b1, 2'b01, a};
            OP_ERASE: return {1'b1, 2'b11, a};
            OP_WREN:  return {1'b1, 2'b00, 2'b11, a[4:0]};
            OP_WRALL: return {1'b1, 2'b00, 2'b01, a[4:0]};
            OP_ERALL: return {1'b1, 2'b00, 2'b10, a[4:0]};
            default:  return {1'b1, 2'b00, 2'b00, a[4:0]};
        endcase
    endfunction

    function automatic mw_class_t mw_classify(mw_op_e op);
        mw_class_t c;
        c.is_read  = (op == OP_READ);
        c.has_data = (op == OP_WRITE) || (op == OP_WRALL);
        c.polls    = (op == OP_WRITE) || (op == OP_ERASE) ||
                     (op == OP_WRALL) || (op == OP_ERALL);
        return c;
    endfunction

endpackage

// File: rtl/mw_timer.sv
module mw_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/mw_txshift.sv
module mw_txshift #(
    parameter int W = 26
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst)
            sr_q <= '0;
        else if (load)
            sr_q <= din;
        else if (shift)
            sr_q <= {sr_q[W-2:0], 1'b0};
    end

    assign msb = sr_q[W-1];
endmodule

// File: rtl/mw_seq.sv
module mw_seq
    import mw_pkg::*;
#(
    parameter int T_SKH    = 2,
    parameter int T_SKL    = 2,
    parameter int T_CSS    = 3,
    parameter int T_CS     = 2,
    parameter int T_DIS    = 1,
    parameter int T_POLL   = 4,
    parameter int POLL_MAX = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [2:0]  op_i,
    input  logic [6:0]  addr_i,
    input  logic [15:0] wdata_i,
    input  logic [3:0]  data_bits_m1_i,
    input  logic [3:0]  read_bits_m1_i,
    input  logic        eep_do_i,
    output logic        eep_cs_o,
    output logic        eep_sclk_o,
    output logic        eep_di_o,
    output logic        busy_o,
    output logic        done_o,
    output logic [15:0] rdata_o,
    output logic        timeout_o
);
    localparam int T_A   = (T_SKH > T_SKL) ? T_SKH : T_SKL;
    localparam int T_B   = (T_CSS > T_CS) ? T_CSS : T_CS;
    localparam int T_C   = (T_DIS > T_POLL) ? T_DIS : T_POLL;
    localparam int T_AB  = (T_A > T_B) ? T_A : T_B;
    localparam int T_MAX = (T_AB > T_C) ? T_AB : T_C;
    localparam int CW    = $clog2(T_MAX + 1);
    localparam int PW    = $clog2(POLL_MAX + 1);
    localparam int BW    = $clog2(FRAME_MAX + 1);

    mw_state_e       state_q, nxt_state;
    mw_stage_e       stage_q;
    mw_class_t       cls_q, cls_in;
    logic [BW-1:0]   bits_left_q;
    logic [4:0]      rx_left_q;
    logic [3:0]      rd_m1_q;
    logic [PW-1:0]   poll_cnt_q;
    logic [15:0]     rdata_q;
    logic            timeout_q, done_q;
    logic            fire, t_exp, tx_msb;
    logic [15:0]     wdata_al;
    logic [FRAME_MAX-1:0] frame_in;
    logic [BW-1:0]   total_bits;
    logic            poll_last;

    function automatic logic [CW-1:0] dur_m1(mw_state_e s);
        case (s)
            ST_CSS:   return CW'(T_CSS - 1);
            ST_SETUP: return CW'(T_DIS - 1);
            ST_HIGH:  return CW'(T_SKH - 1);
            ST_LOW:   return CW'(T_SKL - 1);
            ST_CSLO:  return CW'(T_CS - 1);
            ST_POLL:  return CW'(T_POLL - 1);
            ST_END:   return CW'(T_CS - 1);
            default:  return '0;
        endcase
    endfunction

    assign cls_in     = mw_classify(mw_op_e'(op_i));
    assign wdata_al   = wdata_i << (4'd15 - data_bits_m1_i);
    assign frame_in   = {mw_header(mw_op_e'(op_i), addr_i), wdata_al};
    assign total_bits = cls_in.has_data ? BW'(HDR_BITS) + BW'(data_bits_m1_i) + BW'(1)
                                        : BW'(HDR_BITS);
    assign poll_last  = (poll_cnt_q == PW'(POLL_MAX - 1));
    assign fire       = (state_q == ST_IDLE) ? start_i : t_exp;

    always_comb begin
        nxt_state = state_q;
        case (state_q)
            ST_IDLE:  nxt_state = ST_CSS;
            ST_CSS:   nxt_state = (stage_q == SG_POLL) ? ST_POLL : ST_SETUP;
            ST_SETUP: nxt_state = ST_HIGH;
            ST_HIGH:  nxt_state = ST_LOW;
            ST_LOW: begin
                case (stage_q)
                    SG_TX: begin
                        if (bits_left_q != BW'(1))
                            nxt_state = ST_SETUP;
                        else if (cls_q.is_read)
                            nxt_state = ST_HIGH;
                        else if (cls_q.polls)
                            nxt_state = ST_CSLO;
                        else
                            nxt_state = ST_END;
                    end
                    SG_DUMMY: nxt_state = ST_HIGH;
                    SG_RX:    nxt_state = (rx_left_q == 5'd1) ? ST_END : ST_HIGH;
                    default:  nxt_state = ST_END;
                endcase
            end
            ST_CSLO:  nxt_state = ST_CSS;
            ST_POLL:  nxt_state = (eep_do_i || poll_last) ? ST_END : ST_POLL;
            ST_END:   nxt_state = ST_IDLE;
            default:  nxt_state = ST_IDLE;
        endcase
    end

    mw_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (fire),
        .val     (dur_m1(nxt_state)),
        .expired (t_exp)
    );

    mw_txshift #(.W(FRAME_MAX)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .load  (fire && state_q == ST_IDLE),
        .din   (frame_in),
        .shift (fire && state_q == ST_LOW && stage_q == SG_TX),
        .msb   (tx_msb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            stage_q     <= SG_TX;
            cls_q       <= '0;
            bits_left_q <= '0;
            rx_left_q   <= '0;
            rd_m1_q     <= '0;
            poll_cnt_q  <= '0;
            rdata_q     <= '0;
            timeout_q   <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            done_q <= fire && (state_q == ST_END);
            if (fire) begin
                state_q <= nxt_state;
                case (state_q)
                    ST_IDLE: begin
                        cls_q       <= cls_in;
                        rd_m1_q     <= read_bits_m1_i;
                        bits_left_q <= total_bits;
                        stage_q     <= SG_TX;
                        rdata_q     <= '0;
                        timeout_q   <= 1'b0;
                        poll_cnt_q  <= '0;
                    end
                    ST_LOW: begin
                        case (stage_q)
                            SG_TX: begin
                                bits_left_q <= bits_left_q - 1'b1;
                                if (bits_left_q == BW'(1)) begin
                                    if (cls_q.is_read)
                                        stage_q <= SG_DUMMY;
                                    else if (cls_q.polls)
                                        stage_q <= SG_POLL;
                                end
                            end
                            SG_DUMMY: begin
                                stage_q   <= SG_RX;
                                rx_left_q <= {1'b0, rd_m1_q} + 5'd1;
                            end
                            SG_RX: begin
                                rdata_q   <= {rdata_q[14:0], eep_do_i};
                                rx_left_q <= rx_left_q - 1'b1;
                            end
                            default: ;
                        endcase
                    end
                    ST_POLL: begin
                        if (!eep_do_i) begin
                            poll_cnt_q <= poll_cnt_q + 1'b1;
                            if (poll_last)
                                timeout_q <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign eep_cs_o   = (state_q == ST_CSS) || (state_q == ST_SETUP) || (state_q == ST_HIGH) ||
                        (state_q == ST_LOW) || (state_q == ST_POLL);
    assign eep_sclk_o = (state_q == ST_HIGH);
    assign eep_di_o   = (stage_q == SG_TX) && tx_msb &&
                        ((state_q == ST_SETUP) || (state_q == ST_HIGH) || (state_q == ST_LOW));
    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = done_q;
    assign rdata_o    = rdata_q;
    assign timeout_o  = timeout_q;

    a_r1_idle_pins_low: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!eep_cs_o && !eep_sclk_o && !eep_di_o));
    a_r4_clock_inside_select: assert property (@(posedge clk) disable iff (rst)
        eep_sclk_o |-> eep_cs_o);
    a_r4_di_steady_on_high: assert property (@(posedge clk) disable iff (rst)
        (eep_sclk_o && $past(eep_sclk_o)) |-> $stable(eep_di_o));
    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    a_r6_poll_bounded: assert property (@(posedge clk) disable iff (rst)
        poll_cnt_q <= PW'(POLL_MAX));
    a_r7_timeout_after_poll: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_o) |-> ($past(state_q) == ST_POLL));
    a_r10_start_ignored_busy: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(cls_q));
endmodule

// File: tb/mw_seq_tb.sv
module mw_seq_tb_top;
    localparam int CLK_PER  = 10;
    localparam int P_SKH    = 2;
    localparam int P_SKL    = 2;
    localparam int P_CSS    = 3;
    localparam int P_CS     = 2;
    localparam int P_DIS    = 1;
    localparam int P_POLL   = 4;
    localparam int P_PMAX   = 10;

    typedef struct packed {
        logic cs, sclk, di, busy, done, dov;
    } ent_t;

    logic clk = 1'b0, rst = 1'b1;
    logic start = 1'b0;
    logic [2:0] op = '0;
    logic [6:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [3:0] dm1 = '0, rm1 = '0;
    logic do_i = 1'b0;
    logic cs, sclk, di, busy, done, tmo;
    logic [15:0] rdata;

    ent_t  q[$];
    string tq[$];
    logic [15:0] exp_rd = '0;
    logic exp_err = 1'b0;
    logic poking = 1'b0;
    int checks = 0, errors = 0, cyc = 0;

    always #(CLK_PER/2) clk = ~clk;

    mw_seq #(.T_SKH(P_SKH), .T_SKL(P_SKL), .T_CSS(P_CSS), .T_CS(P_CS), .T_DIS(P_DIS),
             .T_POLL(P_POLL), .POLL_MAX(P_PMAX)) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .op_i(op), .addr_i(addr), .wdata_i(wdata),
        .data_bits_m1_i(dm1), .read_bits_m1_i(rm1), .eep_do_i(do_i),
        .eep_cs_o(cs), .eep_sclk_o(sclk), .eep_di_o(di), .busy_o(busy), .done_o(done),
        .rdata_o(rdata), .timeout_o(tmo));

    function automatic logic [9:0] hdr_of(logic [2:0] o, logic [6:0] a);
        case (o)
            3'd0: return {1'b1, 2'b10, a};
            3'd1: return {1'b1, 2'b01, a};
            3'd2: return {1'b1, 2'b11, a};
            3'd3: return {1'b1, 2'b00, 2'b11, a[4:0]};
            3'd5: return {1'b1, 2'b00, 2'b01, a[4:0]};
            3'd6: return {1'b1, 2'b00, 2'b10, a[4:0]};
            default: return {1'b1, 2'b00, 2'b00, a[4:0]};
        endcase
    endfunction

    task automatic push(int n, logic c, logic s, logic d, logic dv, string t);
        for (int i = 0; i < n; i++) begin
            q.push_back('{cs: c, sclk: s, di: d, busy: 1'b1, done: 1'b0, dov: dv});
            tq.push_back(t);
        end
    endtask

    // Behavioural expected pin sequence, cycle by cycle
    task automatic run_op(logic [2:0] o, logic [6:0] a, logic [15:0] wd, int dm, int rm,
                          logic [15:0] pat, int ready, int poke);
        logic [9:0] h;
        bit rd_op, dat_op, poll_op;
        string tend;
        h = hdr_of(o, a);
        rd_op   = (o == 3'd0);
        dat_op  = (o == 3'd1) || (o == 3'd5);
        poll_op = (o == 3'd1) || (o == 3'd2) || (o == 3'd5) || (o == 3'd6);
        tend = (o == 3'd3 || o == 3'd4 || o == 3'd7) ? "R8" : "R3";
        @(negedge clk); #1;
        push(P_CSS, 1, 0, 0, 0, "R3");
        for (int i = 9; i >= 0; i--) begin
            push(P_DIS, 1, 0, h[i], 0, "R2");
            push(P_SKH, 1, 1, h[i], 0, "R2");
            push(P_SKL, 1, 0, h[i], 0, "R2");
        end
        if (dat_op)
            for (int i = dm; i >= 0; i--) begin
                push(P_DIS, 1, 0, wd[i], 0, "R4");
                push(P_SKH, 1, 1, wd[i], 0, "R4");
                push(P_SKL, 1, 0, wd[i], 0, "R4");
            end
        exp_rd  = '0;
        exp_err = 1'b0;
        if (rd_op) begin
            push(P_SKH, 1, 1, 0, 0, "R5");
            push(P_SKL, 1, 0, 0, 0, "R5");
            for (int k = rm; k >= 0; k--) begin
                push(P_SKH, 1, 1, 0, pat[k], "R5");
                push(P_SKL, 1, 0, 0, pat[k], "R5");
                exp_rd = {exp_rd[14:0], pat[k]};
            end
        end
        if (poll_op) begin
            push(P_CS, 0, 0, 0, 0, "R6");
            push(P_CSS, 1, 0, 0, 0, "R6");
            for (int p = 0; p < P_PMAX; p++) begin
                push(P_POLL, 1, 0, 0, (p == ready), (p == P_PMAX - 1) ? "R7" : "R6");
                if (p == ready) break;
            end
            exp_err = (ready >= P_PMAX);
        end
        push(P_CS, 0, 0, 0, 0, tend);
        q.push_back('{cs: 0, sclk: 0, di: 0, busy: 0, done: 1, dov: 0});
        tq.push_back("R9");
        op = o; addr = a; wdata = wd; dm1 = dm[3:0]; rm1 = rm[3:0];
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (poke > 0) begin
            repeat (poke) @(posedge clk);
            #1;
            poking = 1'b1;
            op = 3'd0; addr = ~a; wdata = ~wd; dm1 = 4'd3; rm1 = 4'd2;
            start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
        end
        while (q.size() != 0) @(posedge clk);
        poking = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    always @(negedge clk) begin
        ent_t e;
        string t;
        if (!rst) begin
            cyc++;
            if (q.size() > 0) begin
                e = q.pop_front();
                t = tq.pop_front();
            end else begin
                e = '0;
                t = "R1";
            end
            if (poking) t = "R10";
            do_i = e.dov;
            checks++;
            if ({cs, sclk, di, busy, done} !== {e.cs, e.sclk, e.di, e.busy, e.done}) begin
                errors++;
                $display("FAIL %s cycle %0d pins cs/sclk/di/busy/done actual=%b expected=%b",
                         t, cyc, {cs, sclk, di, busy, done},
                         {e.cs, e.sclk, e.di, e.busy, e.done});
            end
            if (!e.busy) begin
                checks++;
                if (rdata !== exp_rd) begin
                    errors++;
                    $display("FAIL %s rdata actual=%h expected=%h", e.done ? "R5" : "R9",
                             rdata, exp_rd);
                end
                checks++;
                if (tmo !== exp_err) begin
                    errors++;
                    $display("FAIL %s timeout actual=%b expected=%b", e.done ? "R7" : "R9",
                             tmo, exp_err);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        repeat (6) @(posedge clk);                           // R1 idle after reset
        run_op(3'd0, 7'h2A, 16'h0, 0, 15, 16'hBEEF, 99, 0);  // R5 full-length read
        run_op(3'd0, 7'h55, 16'h0, 0, 0, 16'h0001, 99, 0);   // R5 one-bit read
        run_op(3'd0, 7'h13, 16'h0, 0, 4, 16'h0015, 99, 0);   // R5 five-bit read
        run_op(3'd1, 7'h7F, 16'hA5C3, 15, 0, 16'h0, 3, 0);   // R4 R6 write, ready at 4th poll
        run_op(3'd2, 7'h01, 16'h0, 0, 0, 16'h0, 99, 0);      // R7 erase timeout
        run_op(3'd3, 7'h1F, 16'h0, 0, 0, 16'h0, 99, 0);      // R8 enable
        run_op(3'd4, 7'h00, 16'h0, 0, 0, 16'h0, 99, 0);      // R8 disable
        run_op(3'd7, 7'h0A, 16'h0, 0, 0, 16'h0, 99, 0);      // R2 reserved code acts as disable
        run_op(3'd5, 7'h0C, 16'h0001, 0, 0, 16'h0, 0, 0);    // R4 write-all 1 bit, ready first
        run_op(3'd6, 7'h33, 16'h0, 0, 0, 16'h0, 9, 0);       // R6 erase-all ready at last poll
        run_op(3'd1, 7'h40, 16'h00F0, 7, 0, 16'h0, 2, 5);    // R10 start ignored while busy
        run_op(3'd0, 7'h21, 16'h0, 0, 7, 16'h00C6, 99, 12);  // R10 poke during read
        repeat (5) @(posedge clk);                           // R9 results held while idle
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule